// File: doc/BRIEF.md
# DRAM Clock-Enable Power Controller

This block sets the clock-enable level and the pad output enables for a four-rank SDRAM interface. After reset it keeps every clock enable low until software writes a release value into its configuration port. It tracks which ranks are fitted so that empty rank sites are not driven. While the package sits in a deep low-power state with no memory traffic, it moves all ranks into self-refresh and later wakes them again.

A suspend request drains outstanding memory cycles and then parks every rank in self-refresh. A done flag reports when the memory is safe to leave. Pulses to the command logic mark the start and the end of each self-refresh period. A ready output tells request sources when the interface accepts traffic.

Top module: `dram_cke_ctl`

## Requirements
- R1: While `rst_n` is low, `cke` is 4'b0000, `cke_oe` and `cs_oe` are 4'b1111 (every rank treated as fitted), and `req_ready`, `sr_enter`, `sr_exit` and `susp_done` are 0.
- R2: After reset, `cke` stays 4'b0000 until a clock edge samples `cfg_wr`=1 with `cfg_wdata`=1. A write with `cfg_wdata`=0 has no effect. `cke` rises right after the releasing edge, and `req_ready` rises with it.
- R3: In the active state, `cke[i]`=1 for every rank whose enable bit is 1, and `cke_oe[i]` and `cs_oe[i]` both equal the stored fitted bit for rank i.
- R4: A rank stored as absent has `cke_oe[i]`=`cs_oe[i]`=0 and `cke[i]`=0.
- R5: `rank_present` is taken in only at edges where clock enable is low (before release, in self-refresh, in suspend). Changes made while clock enable is high do not alter `cke_oe`.
- R6: From the active state, a `pkg_state` of 3 or 6 with `pend_cnt`=0 and `req_new`=0 gives a one-cycle `sr_enter` pulse while `cke` is still high. `cke` goes to 0 in the next cycle. Any other `pkg_state` code keeps the ranks active.
- R7: A non-zero `pend_cnt` blocks self-refresh entry.
- R8: In low-power self-refresh, any of `req_new`=1, `pend_cnt`≠0 or a `pkg_state` other than 3 or 6 wakes the ranks. The next cycle has `cke` high with a one-cycle `sr_exit` pulse and `req_ready`=0. `req_ready` returns one cycle later.
- R9: With `suspend_req`=1, `req_ready` drops while `pend_cnt` drains. Once the count is 0, an `sr_enter` pulse follows, and then `cke` is 0 with `susp_done`=1 until `suspend_req` falls. The wake sequence of R8 follows.
- R10: `suspend_req` has priority over low-power entry. If it arrives during self-refresh, it moves straight to the suspend state with `susp_done`=1 and gives no extra `sr_enter` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 1 | Release bit written with the strobe |
| rank_present | input | 4 | Fitted-rank mask, 1 = fitted |
| pkg_state | input | 3 | Package power-state code |
| pend_cnt | input | 8 | Outstanding memory request count |
| req_new | input | 1 | New request arriving this cycle |
| suspend_req | input | 1 | Suspend-to-memory request |
| cke | output | 4 | Clock enable per rank |
| cke_oe | output | 4 | Clock-enable pad output enable per rank |
| cs_oe | output | 4 | Chip-select pad output enable per rank |
| sr_enter | output | 1 | Self-refresh entry command pulse |
| sr_exit | output | 1 | Self-refresh exit command pulse |
| req_ready | output | 1 | Interface accepts requests |
| susp_done | output | 1 | Suspend flush complete, ranks in self-refresh |

## Verification
A wrong controller state appears at the ports within one cycle. A wrong state shows as a clock-enable level that does not match, a missing or extra entry or exit pulse, or `req_ready` asserted during a flush or a wake cycle. A stale or wrongly latched fitted mask shows on `cke_oe` and `cs_oe` at the first low-enable edge, or as a change while ranks are live. The sequences pass through reset release, both low-power codes, a non-matching code, pending traffic, a suspend from the active state and a suspend from self-refresh. Every cycle is compared against a queued expectation.

// File: rtl/dram_cke_ctl.sv
module dram_cke_ctl #(
  parameter int NR = 4,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_wdata,
  input  logic [NR-1:0] rank_present,
  input  logic [2:0]    pkg_state,
  input  logic [PW-1:0] pend_cnt,
  input  logic          req_new,
  input  logic          suspend_req,
  output logic [NR-1:0] cke,
  output logic [NR-1:0] cke_oe,
  output logic [NR-1:0] cs_oe,
  output logic          sr_enter,
  output logic          sr_exit,
  output logic          req_ready,
  output logic          susp_done
);
  localparam logic [2:0] PKG_DEEP_A = 3'd3;
  localparam logic [2:0] PKG_DEEP_B = 3'd6;

  typedef enum logic [2:0] {
    S_OFF, S_ACTIVE, S_ENTRY, S_SR, S_EXIT, S_FLUSH, S_SENTRY, S_SUSP
  } st_t;

  st_t st, st_nx;
  logic [NR-1:0] fitted;
  logic cke_on, deep, idle;

  assign deep   = (pkg_state == PKG_DEEP_A) || (pkg_state == PKG_DEEP_B);
  assign idle   = (pend_cnt == '0) && !req_new;
  assign cke_on = (st == S_ACTIVE) || (st == S_ENTRY) || (st == S_EXIT) ||
                  (st == S_FLUSH) || (st == S_SENTRY);

  always_comb begin
    st_nx = st;
    case (st)
      S_OFF:    if (cfg_wr && cfg_wdata) st_nx = S_ACTIVE;
      S_ACTIVE: if (suspend_req) st_nx = S_FLUSH;
                else if (deep && idle) st_nx = S_ENTRY;
      S_ENTRY:  st_nx = S_SR;
      S_SR:     if (suspend_req) st_nx = S_SUSP;
                else if (!deep || !idle) st_nx = S_EXIT;
      S_EXIT:   st_nx = S_ACTIVE;
      S_FLUSH:  if (!suspend_req) st_nx = S_ACTIVE;
                else if (pend_cnt == '0) st_nx = S_SENTRY;
      S_SENTRY: st_nx = S_SUSP;
      S_SUSP:   if (!suspend_req) st_nx = S_EXIT;
      default:  st_nx = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_OFF;
      fitted <= '1;
    end else begin
      st <= st_nx;
      if (!cke_on) fitted <= rank_present;
    end
  end

  assign cke       = cke_on ? fitted : '0;
  assign cke_oe    = fitted;
  assign cs_oe     = fitted;
  assign sr_enter  = (st == S_ENTRY) || (st == S_SENTRY);
  assign sr_exit   = (st == S_EXIT);
  assign req_ready = (st == S_ACTIVE);
  assign susp_done = (st == S_SUSP);

  assert_release_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cke_on) && $past(st) == S_OFF) |-> $past(cfg_wr && cfg_wdata));
  assert_absent_undriven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cke & ~cke_oe) == '0);
  assert_mask_frozen_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cke_on) && cke_on) |-> $stable(cke_oe));
  assert_entry_before_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cke_on) && $past(st) != S_OFF) |-> $past(sr_enter));
  assert_exit_before_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> ($past(sr_exit) || $past(st) == S_OFF || $past(st) == S_FLUSH));
  assert_done_cke_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    susp_done |-> (cke == '0 && !req_ready));
  assert_pulses_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sr_enter, sr_exit, req_ready, susp_done}));
endmodule

// File: tb/dram_cke_ctl_test.sv
module dram_cke_ctl_test;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_wr = 0, cfg_wdata = 0, req_new = 0, suspend_req = 0;
  logic [3:0] rank_present = 4'hF;
  logic [2:0] pkg_state = 3'd0;
  logic [7:0] pend_cnt = 8'd0;
  logic [3:0] cke, cke_oe, cs_oe;
  logic sr_enter, sr_exit, req_ready, susp_done;

  int checks = 0, fails = 0;

  typedef struct {
    logic [3:0] cke;
    logic [3:0] oe;
    logic [3:0] fl;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  dram_cke_ctl uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .rank_present(rank_present), .pkg_state(pkg_state), .pend_cnt(pend_cnt),
    .req_new(req_new), .suspend_req(suspend_req), .cke(cke), .cke_oe(cke_oe),
    .cs_oe(cs_oe), .sr_enter(sr_enter), .sr_exit(sr_exit),
    .req_ready(req_ready), .susp_done(susp_done)
  );

  function automatic void compare(exp_t e);
    logic [3:0] fl;
    fl = {req_ready, sr_enter, sr_exit, susp_done};
    checks++;
    if (cke !== e.cke || cke_oe !== e.oe || cs_oe !== e.oe || fl !== e.fl) begin
      fails++;
      $display("FAIL %s: cke=%b oe=%b cs=%b fl=%b expected cke=%b oe=%b fl=%b",
               e.tag, cke, cke_oe, cs_oe, fl, e.cke, e.oe, e.fl);
    end
  endfunction

  task automatic cyc(input logic [3:0] c, input logic [3:0] o, input logic [3:0] f,
                     input string tag);
    exp_t e;
    e.cke = c; e.oe = o; e.fl = f; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    r.cke = 4'h0; r.oe = 4'hF; r.fl = 4'b0000; r.tag = "R1 reset";
    compare(r);
    rst_n = 1;
    cyc(4'h0, 4'hF, 4'b0000, "R2 held low");
    cfg_wr = 1; cfg_wdata = 0; rank_present = 4'b1011;
    cyc(4'h0, 4'b1011, 4'b0000, "R2 zero write ignored");
    cfg_wdata = 1;
    cyc(4'b1011, 4'b1011, 4'b1000, "R3 R4 release");
    cfg_wr = 0; cfg_wdata = 0; rank_present = 4'hF;
    cyc(4'b1011, 4'b1011, 4'b1000, "R5 live mask ignored");
    pkg_state = 3'd5;
    cyc(4'b1011, 4'b1011, 4'b1000, "R6 other code active");
    pkg_state = 3'd3; pend_cnt = 8'd2;
    cyc(4'b1011, 4'b1011, 4'b1000, "R7 pending blocks");
    pend_cnt = 8'd0;
    cyc(4'b1011, 4'b1011, 4'b0100, "R6 entry pulse");
    cyc(4'h0, 4'b1011, 4'b0000, "R6 cke low");
    cyc(4'h0, 4'hF, 4'b0000, "R5 mask taken in low");
    req_new = 1;
    cyc(4'hF, 4'hF, 4'b0010, "R8 exit pulse");
    req_new = 0; pkg_state = 3'd0;
    cyc(4'hF, 4'hF, 4'b1000, "R8 ready after exit");
    pkg_state = 3'd6;
    cyc(4'hF, 4'hF, 4'b0100, "R6 code6 entry");
    cyc(4'h0, 4'hF, 4'b0000, "R6 code6 low");
    pkg_state = 3'd0;
    cyc(4'hF, 4'hF, 4'b0010, "R8 state leave exit");
    cyc(4'hF, 4'hF, 4'b1000, "R8 ready");
    suspend_req = 1; pend_cnt = 8'd3; pkg_state = 3'd6;
    cyc(4'hF, 4'hF, 4'b0000, "R10 suspend beats deep");
    pend_cnt = 8'd1;
    cyc(4'hF, 4'hF, 4'b0000, "R9 flushing");
    pend_cnt = 8'd0;
    cyc(4'hF, 4'hF, 4'b0100, "R9 entry pulse");
    cyc(4'h0, 4'hF, 4'b0001, "R9 done");
    rank_present = 4'b0111;
    cyc(4'h0, 4'b0111, 4'b0001, "R9 R5 done holds");
    suspend_req = 0; pkg_state = 3'd0;
    cyc(4'b0111, 4'b0111, 4'b0010, "R9 exit after suspend");
    cyc(4'b0111, 4'b0111, 4'b1000, "R9 ready");
    pkg_state = 3'd3;
    cyc(4'b0111, 4'b0111, 4'b0100, "R6 entry again");
    cyc(4'h0, 4'b0111, 4'b0000, "R6 low again");
    suspend_req = 1;
    cyc(4'h0, 4'b0111, 4'b0001, "R10 sr to suspend");
    suspend_req = 0;
    cyc(4'b0111, 4'b0111, 4'b0010, "R10 exit");
    pkg_state = 3'd0;
    cyc(4'b0111, 4'b0111, 4'b1000, "R3 active");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule